// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged Cache Lookup

This block is the lookup stage of a 64 KB direct-mapped cache with 32-byte lines. A load or fetch presents a 32-bit virtual address. On that same clock edge the block starts reads of the tag array, the line-data array and a per-line valid vector. Each read uses the 11-bit line index taken from the virtual address. In the following cycle the translation unit returns the 18-bit physical frame number and a translation-hit flag. The block then compares the stored 16-bit physical tag against the upper frame bits and registers a hit or miss together with the full line.

The line index and line offset together span 16 address bits, but a page offset covers only 14. The two highest index bits therefore come from the virtual page number. The block flags every result in which those two bits disagree with the matching bits of the translated frame, so that a later stage can deal with a possible second copy of the line. When translation misses, or has not yet answered, the block stalls. It keeps the array words it has already read and retries the comparison on each later cycle until a valid translation arrives. A separate fill port writes a tag and a line into one index and marks that line valid.

Top module: `vipt_lookup`

## Requirements
- R1: During and after a synchronous active-high reset, res_valid, res_hit, res_miss, res_alias, stall and res_data are all 0. Every line is invalid, so the first lookup after reset reports a miss.
- R2: The line index is req_vaddr[15:5]. Bits [4:0] do not change the outcome of a lookup.
- R3: A request is sampled on clock edge N. A translation with xlt_valid=1 and xlt_hit=1 is sampled on edge N+1. The result is then visible on res_valid/res_hit/res_miss/res_alias/res_data after edge N+1.
- R4: A hit (res_hit=1) requires the indexed line to be valid and its stored tag to equal xlt_pfn[17:2], which is physical address bits [31:16]. On a hit, res_data carries the stored 256-bit line.
- R5: When the stored tag differs, or the line is invalid, the result has res_miss=1 and res_hit=0. Whenever res_valid=1, exactly one of res_hit and res_miss is 1.
- R6: res_alias is 1 exactly when req_vaddr[15:14] differs from xlt_pfn[1:0]. It is reported with every result, whether hit or miss.
- R7: Suppose a lookup is pending and on some edge xlt_valid=0 or xlt_hit=0. Then stall is 1 after that edge and no result is produced. A later translation hit completes the lookup using the array contents read when the request was taken, without reading the arrays again.
- R8: A request presented while a lookup is pending and not resolving on that edge is dropped. It produces no result at all.
- R9: fill_en=1 on an edge writes fill_tag and fill_data at fill_index and marks that line valid. Requests sampled on later edges see the new contents.
- R10: A request presented on the same edge at which a pending lookup resolves is accepted. Its result follows one cycle after the earlier result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | 32 | Virtual address of the request |
| xlt_valid | input | 1 | Translation response present |
| xlt_hit | input | 1 | Translation found a mapping |
| xlt_pfn | input | 18 | Translated physical frame number |
| fill_en | input | 1 | Write one line into the arrays |
| fill_index | input | 11 | Line index for the fill |
| fill_tag | input | 16 | Physical tag for the fill |
| fill_data | input | 256 | Line contents for the fill |
| res_valid | output | 1 | Lookup result present |
| res_hit | output | 1 | Result is a hit |
| res_miss | output | 1 | Result is a miss |
| res_alias | output | 1 | Upper index bits disagree with physical bits |
| res_data | output | 256 | Line read for the result |
| stall | output | 1 | Pending lookup waits for translation |

## Verification
The bench targets the stall path. It refills the indexed line while the lookup is waiting and also presents a competing request. A design that re-read the arrays on retry would report a hit with the new line instead of the original one. A design that queued the competing request would emit an extra result. A second group of tests checks alias detection with the tag matching and the frame's low bits both equal and unequal; a design that compared the wrong bits would flip res_alias independently of hit. Further tests cover offset bits that must be ignored, a one-bit tag mismatch, and a request accepted on the resolving edge. A design that blocked on that edge would lose the second result.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
  // Default geometry: 64 KB direct mapped, 32-byte lines, 16 KB pages
  localparam int DEF_ADDR_W     = 32;
  localparam int DEF_PAGE_OFF_W = 14;
  localparam int DEF_LINE_OFF_W = 5;
  localparam int DEF_INDEX_W    = 11;
endpackage

// File: rtl/vipt_sync_ram.sv
module vipt_sync_ram #(
  parameter int WIDTH  = 16,
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WIDTH-1:0]  wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WIDTH-1:0]  rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // read-first: a same-edge write is not forwarded
  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/vipt_valid_vec.sv
module vipt_valid_vec #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_en,
  input  logic [ADDR_W-1:0] set_idx,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_idx,
  output logic              rd_bit
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0] bits;

  always_ff @(posedge clk) begin
    if (rst) begin
      bits   <= '0;
      rd_bit <= 1'b0;
    end else begin
      if (set_en) bits[set_idx] <= 1'b1;
      if (rd_en)  rd_bit <= bits[rd_idx];
    end
  end

  assert_fill_marks_valid_R9: assert property (@(posedge clk) disable iff (rst)
    set_en |=> bits[$past(set_idx)]);
endmodule

// File: rtl/vipt_compare.sv
module vipt_compare #(
  parameter int TAG_W   = 16,
  parameter int ALIAS_W = 2,
  localparam int PFN_W  = TAG_W + ALIAS_W,
  localparam int AW     = (ALIAS_W > 0) ? ALIAS_W : 1
) (
  input  logic             line_valid,
  input  logic [TAG_W-1:0] stored_tag,
  input  logic [AW-1:0]    virt_hi_idx,
  input  logic [PFN_W-1:0] pfn,
  output logic             hit,
  output logic             alias_risk
);
  assign hit = line_valid && (stored_tag == pfn[PFN_W-1 -: TAG_W]);

  generate
    if (ALIAS_W > 0) begin : g_alias
      assign alias_risk = (virt_hi_idx != pfn[AW-1:0]);
    end else begin : g_no_alias
      logic unused_hi_idx;
      assign unused_hi_idx = ^virt_hi_idx;
      assign alias_risk = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/vipt_lookup.sv
module vipt_lookup
  import vipt_pkg::*;
#(
  parameter int ADDR_W     = DEF_ADDR_W,
  parameter int PAGE_OFF_W = DEF_PAGE_OFF_W,
  parameter int LINE_OFF_W = DEF_LINE_OFF_W,
  parameter int INDEX_W    = DEF_INDEX_W,
  localparam int TAG_W     = ADDR_W - INDEX_W - LINE_OFF_W,
  localparam int PFN_W     = ADDR_W - PAGE_OFF_W,
  localparam int ALIAS_W   = INDEX_W + LINE_OFF_W - PAGE_OFF_W,
  localparam int AW        = (ALIAS_W > 0) ? ALIAS_W : 1,
  localparam int LINE_W    = 8 << LINE_OFF_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [ADDR_W-1:0]  req_vaddr,
  input  logic               xlt_valid,
  input  logic               xlt_hit,
  input  logic [PFN_W-1:0]   xlt_pfn,
  input  logic               fill_en,
  input  logic [INDEX_W-1:0] fill_index,
  input  logic [TAG_W-1:0]   fill_tag,
  input  logic [LINE_W-1:0]  fill_data,
  output logic               res_valid,
  output logic               res_hit,
  output logic               res_miss,
  output logic               res_alias,
  output logic [LINE_W-1:0]  res_data,
  output logic               stall
);
  logic [INDEX_W-1:0] req_idx;
  logic [AW-1:0]      req_hi_idx;
  logic               pend;
  logic [AW-1:0]      pend_hi_idx;
  logic               resolve;
  logic               accept;
  logic [TAG_W-1:0]   rd_tag;
  logic [LINE_W-1:0]  rd_line;
  logic               rd_valid;
  logic               cmp_hit;
  logic               cmp_alias;

  assign req_idx = req_vaddr[LINE_OFF_W +: INDEX_W];

  generate
    if (ALIAS_W > 0) begin : g_hi
      assign req_hi_idx = req_vaddr[PAGE_OFF_W +: AW];
    end else begin : g_nohi
      assign req_hi_idx = '0;
    end
  endgenerate

  // tag and offset bits of the virtual address play no part in the lookup
  logic unused_vaddr_bits;
  assign unused_vaddr_bits = ^{req_vaddr[ADDR_W-1:INDEX_W+LINE_OFF_W],
                               req_vaddr[LINE_OFF_W-1:0]};

  assign resolve = pend && xlt_valid && xlt_hit;
  assign accept  = req_valid && (!pend || resolve);

  vipt_sync_ram #(.WIDTH(TAG_W), .ADDR_W(INDEX_W)) u_tag_ram (
    .clk(clk), .we(fill_en), .waddr(fill_index), .wdata(fill_tag),
    .re(accept), .raddr(req_idx), .rdata(rd_tag));

  vipt_sync_ram #(.WIDTH(LINE_W), .ADDR_W(INDEX_W)) u_data_ram (
    .clk(clk), .we(fill_en), .waddr(fill_index), .wdata(fill_data),
    .re(accept), .raddr(req_idx), .rdata(rd_line));

  vipt_valid_vec #(.ADDR_W(INDEX_W)) u_valid (
    .clk(clk), .rst(rst), .set_en(fill_en), .set_idx(fill_index),
    .rd_en(accept), .rd_idx(req_idx), .rd_bit(rd_valid));

  vipt_compare #(.TAG_W(TAG_W), .ALIAS_W(ALIAS_W)) u_cmp (
    .line_valid(rd_valid), .stored_tag(rd_tag), .virt_hi_idx(pend_hi_idx),
    .pfn(xlt_pfn), .hit(cmp_hit), .alias_risk(cmp_alias));

  always_ff @(posedge clk) begin
    if (rst) begin
      pend        <= 1'b0;
      pend_hi_idx <= '0;
      stall       <= 1'b0;
      res_valid   <= 1'b0;
      res_hit     <= 1'b0;
      res_miss    <= 1'b0;
      res_alias   <= 1'b0;
      res_data    <= '0;
    end else begin
      if (accept) begin
        pend        <= 1'b1;
        pend_hi_idx <= req_hi_idx;
      end else if (resolve) begin
        pend <= 1'b0;
      end
      stall     <= pend && !resolve;
      res_valid <= resolve;
      res_hit   <= resolve && cmp_hit;
      res_miss  <= resolve && !cmp_hit;
      res_alias <= resolve && cmp_alias;
      if (resolve) res_data <= rd_line;
    end
  end

  assert_result_after_pending_R3: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(pend));

  assert_one_outcome_R5: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_hit != res_miss));

  assert_quiet_when_idle_R5: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> (!res_hit && !res_miss && !res_alias));

  assert_stall_on_xlt_miss_R7: assert property (@(posedge clk) disable iff (rst)
    (pend && !(xlt_valid && xlt_hit)) |=> (stall && !res_valid));

  assert_hold_on_stall_R7: assert property (@(posedge clk) disable iff (rst)
    stall |-> $stable(res_data));

  assert_back_to_back_R10: assert property (@(posedge clk) disable iff (rst)
    (resolve && req_valid) |=> pend);

  generate
    if (ALIAS_W > 0) begin : g_alias_chk
      assert_alias_bits_R6: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (res_alias == ($past(pend_hi_idx) != $past(xlt_pfn[AW-1:0]))));
    end
  endgenerate
endmodule

// File: tb/vipt_lookup_bench.sv
module vipt_lookup_bench;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst;
  logic         req_valid;
  logic [31:0]  req_vaddr;
  logic         xlt_valid, xlt_hit;
  logic [17:0]  xlt_pfn;
  logic         fill_en;
  logic [10:0]  fill_index;
  logic [15:0]  fill_tag;
  logic [255:0] fill_data;
  logic         res_valid, res_hit, res_miss, res_alias, stall;
  logic [255:0] res_data;

  int n_checks = 0;
  int n_fail   = 0;

  localparam logic [255:0] LINE_A = {8{32'hA5A5_0123}};
  localparam logic [255:0] LINE_B = {8{32'h5A5A_4567}};
  localparam logic [255:0] LINE_C = {8{32'hC3C3_89AB}};

  always #(CLK_PERIOD/2) clk = ~clk;

  vipt_lookup u_vipt_lookup (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .xlt_valid(xlt_valid), .xlt_hit(xlt_hit), .xlt_pfn(xlt_pfn),
    .fill_en(fill_en), .fill_index(fill_index), .fill_tag(fill_tag),
    .fill_data(fill_data), .res_valid(res_valid), .res_hit(res_hit),
    .res_miss(res_miss), .res_alias(res_alias), .res_data(res_data),
    .stall(stall));

  task automatic check(input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // full-result check, sampled just after the resolving edge
  task automatic check_result(input string req, input logic hit, input logic alias_exp,
                              input logic chk_data, input logic [255:0] data);
    check(req, "res_valid", {255'd0, res_valid}, 256'd1);
    check(req, "res_hit",   {255'd0, res_hit},   {255'd0, hit});
    check(req, "res_miss",  {255'd0, res_miss},  {255'd0, !hit});
    check(req, "res_alias", {255'd0, res_alias}, {255'd0, alias_exp});
    check(req, "stall",     {255'd0, stall},     256'd0);
    if (chk_data) check(req, "res_data", res_data, data);
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0; xlt_valid = 1'b0; xlt_hit = 1'b0; fill_en = 1'b0;
  endtask

  task automatic do_fill(input logic [10:0] idx, input logic [15:0] tag,
                         input logic [255:0] data);
    @(negedge clk);
    fill_en = 1'b1; fill_index = idx; fill_tag = tag; fill_data = data;
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  task automatic present_req(input logic [31:0] va);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va;
  endtask

  // translation in the cycle after the request, then sample
  task automatic present_xlt(input logic vld, input logic hit, input logic [17:0] pfn);
    @(negedge clk);
    req_valid = 1'b0;
    xlt_valid = vld; xlt_hit = hit; xlt_pfn = pfn;
    @(posedge clk); #1;
  endtask

  task automatic lookup(input string req, input logic [31:0] va, input logic [17:0] pfn,
                        input logic hit, input logic alias_exp,
                        input logic chk_data, input logic [255:0] data);
    present_req(va);
    present_xlt(1'b1, 1'b1, pfn);
    check_result(req, hit, alias_exp, chk_data, data);
    idle();
  endtask

  function automatic logic [31:0] va_of(input logic [15:0] upper, input logic [10:0] idx,
                                        input logic [4:0] off);
    return {upper, idx, off};
  endfunction

  task automatic t_reset();
    check("R1", "res_valid after reset", {255'd0, res_valid}, 256'd0);
    check("R1", "stall after reset",     {255'd0, stall},     256'd0);
    check("R1", "res_data after reset",  res_data,            256'd0);
    // R1: everything invalid, even with a zero tag that would otherwise match
    lookup("R1", va_of(16'h0000, 11'h000, 5'h0), 18'h00000, 1'b0, 1'b0, 1'b0, '0);
  endtask

  task automatic t_fill_hit();
    do_fill(11'h123, 16'hBEEF, LINE_A);
    // R9/R4: index 0x123 has high bits 00, frame {BEEF,00}
    lookup("R4", va_of(16'h7777, 11'h123, 5'h00), {16'hBEEF, 2'b00}, 1'b1, 1'b0, 1'b1, LINE_A);
    // R2: offset bits do not matter
    lookup("R2", va_of(16'h1111, 11'h123, 5'h1F), {16'hBEEF, 2'b00}, 1'b1, 1'b0, 1'b1, LINE_A);
  endtask

  task automatic t_tag_mismatch();
    lookup("R5", va_of(16'h7777, 11'h123, 5'h04), {16'hBEEE, 2'b00}, 1'b0, 1'b0, 1'b0, '0);
  endtask

  task automatic t_alias();
    do_fill(11'h723, 16'h1234, LINE_B);
    // R6: vaddr[15:14]=11, frame low bits 01 -> alias with a hit
    lookup("R6", va_of(16'h0000, 11'h723, 5'h0), {16'h1234, 2'b01}, 1'b1, 1'b1, 1'b1, LINE_B);
    // R6: low bits equal -> no alias
    lookup("R6", va_of(16'h0000, 11'h723, 5'h0), {16'h1234, 2'b11}, 1'b1, 1'b0, 1'b1, LINE_B);
    // R6: alias still flagged on a miss
    lookup("R6", va_of(16'h0000, 11'h723, 5'h0), {16'h4321, 2'b00}, 1'b0, 1'b1, 1'b0, '0);
  endtask

  task automatic t_stall();
    present_req(va_of(16'h0000, 11'h123, 5'h0));
    present_xlt(1'b1, 1'b0, {16'hBEEF, 2'b00});           // translation miss
    check("R7", "stall after xlt miss", {255'd0, stall},     256'd1);
    check("R7", "no result on stall",   {255'd0, res_valid}, 256'd0);
    // while waiting: refill the same index and offer a competing request
    @(negedge clk);
    xlt_valid = 1'b0; xlt_hit = 1'b0;
    fill_en = 1'b1; fill_index = 11'h123; fill_tag = 16'h5555; fill_data = LINE_C;
    req_valid = 1'b1; req_vaddr = va_of(16'h0000, 11'h723, 5'h0);
    @(posedge clk); #1;
    check("R7", "stall with no xlt", {255'd0, stall}, 256'd1);
    @(negedge clk);
    fill_en = 1'b0; req_valid = 1'b0;
    xlt_valid = 1'b1; xlt_hit = 1'b1; xlt_pfn = {16'hBEEF, 2'b00};
    @(posedge clk); #1;
    // R7: held array words from the original read give the old line
    check_result("R7", 1'b1, 1'b0, 1'b1, LINE_A);
    idle();
    @(posedge clk); #1;
    check("R8", "dropped request gives no result", {255'd0, res_valid}, 256'd0);
    // R9: the fill during the stall did land
    lookup("R9", va_of(16'h0000, 11'h123, 5'h0), {16'h5555, 2'b00}, 1'b1, 1'b0, 1'b1, LINE_C);
  endtask

  task automatic t_back_to_back();
    present_req(va_of(16'h0000, 11'h123, 5'h0));
    @(negedge clk);
    xlt_valid = 1'b1; xlt_hit = 1'b1; xlt_pfn = {16'h5555, 2'b00};
    req_valid = 1'b1; req_vaddr = va_of(16'h0000, 11'h723, 5'h8);
    @(posedge clk); #1;
    check_result("R10", 1'b1, 1'b0, 1'b1, LINE_C);
    @(negedge clk);
    req_valid = 1'b0;
    xlt_valid = 1'b1; xlt_hit = 1'b1; xlt_pfn = {16'h1234, 2'b11};
    @(posedge clk); #1;
    // R3/R10: second result one cycle later
    check_result("R10", 1'b1, 1'b0, 1'b1, LINE_B);
    idle();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_vaddr = '0;
    xlt_valid = 1'b0; xlt_hit = 1'b0; xlt_pfn = '0;
    fill_en = 1'b0; fill_index = '0; fill_tag = '0; fill_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    t_reset();
    t_fill_hit();
    t_tag_mismatch();
    t_alias();
    t_stall();
    t_back_to_back();
    repeat (2) @(posedge clk);
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule